// File: doc/BRIEF.md
# Multiplexed Bus Register Read Port

This block is the slave side of a register read port on a multiplexed address/data bus driven by a 16-bit host. It captures a register index from the shared address/data lines while the address strobe is high. During a read, it steers the two low byte lanes of the data bus between high impedance and driven. Each read access gives one read strobe toward the internal register file. All bus inputs pass through two-flop synchronisers into the internal clock. The tristate decisions are made from these synchronised levels.

Most registers are 8 bits wide. Only the FIFO window (indices 0x80 to 0x87) and the counter window (0x88 to 0x8F) may be read as 16-bit words. If a host asks for a word from any other register, it gets only the low byte and an error flag. A host that reads the same register twice in a row may skip the address phase, because the latched index stays in place until the next strobe pulse. The register file uses the byte-count output to advance a FIFO read pointer by one or two bytes.

Top module: `mbus_rd_port`

## Requirements
- R1: While `ale_i` is high, the register index follows bits 7..0 of `ad_i`. It keeps the last of these values after `ale_i` falls, until the next pulse. Bits 31..8 of `ad_i` have no effect.
- R2: Lane 0 (`data_oe_o[0]`) is driven only while `cs_n_i`, `rd_n_i` and `be_n_i[0]` are all low. Lane 1 follows the same rule with `be_n_i[1]`. If either `cs_n_i` or `rd_n_i` is high, no lane is driven and no strobe is issued.
- R3: `be_n_i[3:2]` have no effect on lane enables, strobe, byte count or error flag.
- R4: When both low enables are low and the latched index lies in 0x80..0x8F, both lanes are driven and `rd_bytes_o` reads 2.
- R5: When both low enables are low and the index lies outside 0x80..0x8F, only lane 0 is driven, `err_o` is 1 and `rd_bytes_o` reads 1.
- R6: A read with no address phase before it uses the index latched for the previous access.
- R7: Each assertion of the read (cs and rd both low) gives exactly one single-cycle `rd_stb_o` pulse, however long the read is held. A byte read reports `rd_bytes_o` = 1 and `err_o` = 0.
- R8: Within 4 clock cycles of `rd_n_i` or `cs_n_i` rising, both lanes return to high impedance.
- R9: Lane enables and the strobe appear within 4 clock cycles of the read inputs settling. While a lane is driven, `data_o` carries `reg_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address strobe, high during address phase |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read, active low |
| be_n_i | input | 4 | Byte enables, active low |
| ad_i | input | 32 | Multiplexed address/data lines (input side) |
| reg_data_i | input | 16 | Read data from register file |
| reg_idx_o | output | 8 | Latched register index |
| rd_stb_o | output | 1 | One-cycle read strobe to register file |
| rd_bytes_o | output | 2 | Bytes delivered by the current access (1 or 2) |
| err_o | output | 1 | High-byte request on an 8-bit register |
| data_o | output | 16 | Data toward the pads |
| data_oe_o | output | 2 | Per-lane output enable |

## Verification
The hardest case to reach is the width decision when the address phase is skipped. The bench latches a FIFO index, finishes one word read, and then starts a second read with no address strobe between the two. It checks that the second read is still treated as a word read. The illegal-word case is set up with both low enables held low against an 8-bit register. The bench then checks that lane 1 stays released while the error flag rises. Long-held reads check that only one strobe is issued.

// File: rtl/mbus_rd_pkg.sv
package mbus_rd_pkg;
    localparam int IDX_W  = 8;
    localparam int LANES  = 2;

    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] idx;
        logic             stb;
        logic             word;
        logic             err;
        logic [LANES-1:0] oe;
    } rd_state_t;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int WIDTH = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] s1_q, s1_d, s2_q, s2_d;

    always_comb begin
        s1_d = async_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/mbus_class.sv
module mbus_class #(
    parameter int IDX_W = 8,
    parameter logic [IDX_W-1:0] FIFO_LO = 8'h80,
    parameter logic [IDX_W-1:0] FIFO_HI = 8'h87,
    parameter logic [IDX_W-1:0] CNT_LO  = 8'h88,
    parameter logic [IDX_W-1:0] CNT_HI  = 8'h8F
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             is_fifo_o,
    output logic             is_word_o
);
    logic is_cnt;
    always_comb begin
        is_fifo_o = (idx_i >= FIFO_LO) && (idx_i <= FIFO_HI);
        is_cnt    = (idx_i >= CNT_LO)  && (idx_i <= CNT_HI);
        is_word_o = is_fifo_o || is_cnt;
    end
endmodule

// File: rtl/mbus_rd_port.sv
module mbus_rd_port
    import mbus_rd_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic [3:0]        be_n_i,
    input  logic [BUS_W-1:0]  ad_i,
    input  logic [DATA_W-1:0] reg_data_i,
    output logic [IDX_W-1:0]  reg_idx_o,
    output logic              rd_stb_o,
    output logic [1:0]        rd_bytes_o,
    output logic              err_o,
    output logic [DATA_W-1:0] data_o,
    output logic [LANES-1:0]  data_oe_o
);
    localparam int CTL_W = 3 + LANES;

    logic [CTL_W-1:0] ctl_s;
    logic [IDX_W-1:0] ad_s;
    logic             ale_s, act_s;
    logic [LANES-1:0] be_s;
    logic             is_fifo, is_word;
    logic             unused_hi;
    rd_state_t        st_d, st_q;

    assign unused_hi = ^{ad_i[BUS_W-1:IDX_W], be_n_i[3:LANES], is_fifo};

    mbus_sync #(.WIDTH(CTL_W), .RST_VAL({3'b011, {LANES{1'b1}}})) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({ale_i, cs_n_i, rd_n_i, be_n_i[LANES-1:0]}),
        .sync_o(ctl_s)
    );

    mbus_sync #(.WIDTH(IDX_W)) u_ad_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i(ad_i[IDX_W-1:0]),
        .sync_o(ad_s)
    );

    assign ale_s = ctl_s[CTL_W-1];
    assign act_s = ~ctl_s[CTL_W-2] & ~ctl_s[CTL_W-3];
    assign be_s  = ctl_s[LANES-1:0];

    mbus_class #(.IDX_W(IDX_W)) u_class (
        .idx_i(st_q.idx), .is_fifo_o(is_fifo), .is_word_o(is_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.act = act_s;
        if (ale_s)
            st_d.idx = ad_s;
        st_d.stb = act_s & ~st_q.act;
        if (act_s & ~st_q.act) begin
            st_d.word = ~be_s[0] & ~be_s[1] & is_word;
            st_d.err  = ~be_s[1] & ~is_word;
        end else if (!act_s) begin
            st_d.word = 1'b0;
            st_d.err  = 1'b0;
        end
        st_d.oe[0] = act_s & ~be_s[0];
        st_d.oe[1] = act_s & ~be_s[1] & is_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_idx_o  = st_q.idx;
    assign rd_stb_o   = st_q.stb;
    assign rd_bytes_o = st_q.word ? 2'd2 : 2'd1;
    assign err_o      = st_q.err;
    assign data_o     = reg_data_i;
    assign data_oe_o  = st_q.oe;
endmodule

// File: rtl/mbus_rd_chk.sv
module mbus_rd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ale_s,
    input logic       act_q,
    input logic       is_word,
    input logic [7:0] reg_idx_o,
    input logic       rd_stb_o,
    input logic [1:0] rd_bytes_o,
    input logic       err_o,
    input logic [1:0] data_oe_o
);
    a_r1_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ale_s) |-> $stable(reg_idx_o));
    a_r2_lane_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o != 2'b00) |-> act_q);
    a_r4_hi_lane_word_only: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o[1] |-> is_word);
    a_r5_err_not_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_o && err_o) |-> !is_word);
    a_r4_two_bytes_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_o && rd_bytes_o == 2'd2) |-> is_word);
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_o |=> !rd_stb_o);
endmodule

bind mbus_rd_port mbus_rd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ale_s(ale_s), .act_q(st_q.act),
    .is_word(is_word), .reg_idx_o(reg_idx_o), .rd_stb_o(rd_stb_o),
    .rd_bytes_o(rd_bytes_o), .err_o(err_o), .data_oe_o(data_oe_o)
);

// File: tb/sim_mbus_rd_port.sv
module sim_mbus_rd_port;
    logic        clk = 0, rst_n = 0;
    logic        ale = 0, cs_n = 1, rd_n = 1;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] ad = '0;
    logic [15:0] rdat = 16'h0000;
    logic [7:0]  idx;
    logic        stb, err;
    logic [1:0]  bytes, oe;
    logic [15:0] dout;
    int n_chk = 0, n_bad = 0, stb_cnt = 0;
    logic [1:0] stb_bytes;
    logic       stb_err;

    always #4 clk = ~clk;

    mbus_rd_port u0 (
        .clk(clk), .rst_n(rst_n), .ale_i(ale), .cs_n_i(cs_n), .rd_n_i(rd_n),
        .be_n_i(be_n), .ad_i(ad), .reg_data_i(rdat), .reg_idx_o(idx),
        .rd_stb_o(stb), .rd_bytes_o(bytes), .err_o(err), .data_o(dout),
        .data_oe_o(oe)
    );

    always @(posedge clk) if (stb) begin
        stb_cnt   <= stb_cnt + 1;
        stb_bytes <= bytes;
        stb_err   <= err;
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic addr_phase(logic [31:0] a);
        ad = a; ale = 1; cyc(3);
        ale = 0; cyc(4);
        ad = 32'hDEAD_BEEF;
    endtask

    task automatic rd_on(logic [3:0] b);
        be_n = b; cs_n = 0; rd_n = 0; rdat = {~idx, idx}; cyc(5);
    endtask

    task automatic rd_off;
        rd_n = 1; cs_n = 1; be_n = 4'hF; cyc(5);
    endtask

    task automatic t_reset;
        chk("R2 reset oe", oe, 0);
        chk("R7 reset stb", stb_cnt, 0);
        chk("R1 reset idx", idx, 0);
        chk("R5 reset err", err, 0);
    endtask

    task automatic t_byte_read;
        int c0;
        addr_phase(32'hABCD_EF12);
        chk("R1 idx low byte", idx, 8'h12);
        c0 = stb_cnt;
        rd_on(4'b1110);
        chk("R9 lane0 on", oe, 2'b01);
        chk("R9 data", dout, {8'hED, 8'h12});
        chk("R7 one strobe", stb_cnt - c0, 1);
        chk("R7 byte count", stb_bytes, 1);
        chk("R7 no err", stb_err, 0);
        rd_off();
        chk("R8 released", oe, 0);
        chk("R1 idx held", idx, 8'h12);
    endtask

    task automatic t_word(logic [7:0] a, string tag);
        addr_phase({24'h5A5A5A, a});
        rd_on(4'b1100);
        chk({tag, " R4 both lanes"}, oe, 2'b11);
        chk({tag, " R4 two bytes"}, stb_bytes, 2);
        chk({tag, " R4 no err"}, stb_err, 0);
        rd_off();
    endtask

    task automatic t_illegal_word;
        addr_phase(32'h0000_0020);
        rd_on(4'b1100);
        chk("R5 lane0 only", oe, 2'b01);
        chk("R5 err", err, 1);
        chk("R5 one byte", stb_bytes, 1);
        rd_off();
        chk("R8 err cleared on release", err, 0);
    endtask

    task automatic t_upper_be;
        addr_phase(32'h0000_0012);
        rd_on(4'b0010);
        chk("R3 upper lanes ignored", oe, 2'b01);
        chk("R3 no err", stb_err, 0);
        chk("R3 byte count", stb_bytes, 1);
        rd_off();
        addr_phase(32'h0000_0084);
        rd_on(4'b0000);
        chk("R3 word with upper low", oe, 2'b11);
        rd_off();
    endtask

    task automatic t_reuse;
        addr_phase(32'h0000_0085);
        rd_on(4'b1100); rd_off();
        rd_on(4'b1100);
        chk("R6 idx reused", idx, 8'h85);
        chk("R6 still word", stb_bytes, 2);
        chk("R6 lanes", oe, 2'b11);
        rd_off();
    endtask

    task automatic t_long_and_gating;
        int c0;
        c0 = stb_cnt;
        rd_on(4'b1110); cyc(20);
        chk("R7 long read single strobe", stb_cnt - c0, 1);
        rd_off();
        c0 = stb_cnt;
        be_n = 4'b1100; cs_n = 1; rd_n = 0; cyc(6);
        chk("R2 cs high no lane", oe, 0);
        chk("R2 cs high no strobe", stb_cnt - c0, 0);
        cs_n = 0; rd_n = 1; cyc(6);
        chk("R2 rd high no lane", oe, 0);
        chk("R2 rd high no strobe", stb_cnt - c0, 0);
        rd_off();
    endtask

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1; cyc(2);
        t_byte_read();
        t_word(8'h83, "fifo");
        t_word(8'h8A, "counter");
        t_illegal_word();
        t_upper_be();
        t_reuse();
        t_long_and_gating();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule